// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block decides, at every instruction boundary signalled by the core, whether one of its maskable interrupt sources is taken. It keeps the state behind that decision. There is one global enable flag and one processor priority level (IPL). Each source has a pending-request bit and a 3-bit priority level. A source qualifies when the enable flag is set, its request is pending and its level is strictly above the IPL. Among the qualifying sources, the highest level wins. When levels tie, the lowest index wins.

The core reports enable-flag changes as tagged commands, and the tag sets when a change takes effect. A change carried by a return-from-interrupt counts at the boundary it arrives with. A change made by an ordinary flag instruction (set, clear, pop, load) is held back. The first boundary at or after the command still decides with the old flag value, and the new value applies from the boundary after that.

When a source is taken, the controller does four things. It clears that source's request, loads the IPL with the winning level, clears the enable flag, and reports the winner one cycle later on a single-cycle strobe.

Top module: `int_accept_top`

## Requirements
- R1: While the effective enable flag is 0, no source is accepted at a boundary, whatever requests and levels are present.
- R2: After reset the enable flag is 0, the IPL is 0, every request bit and level is 0, and `acceptStb` is 0.
- R3: A return-from-interrupt update (`flagUpdEn`=1, `flagUpdRet`=1) is used by the decision at a boundary in the same cycle. It is held in the flag for later boundaries, and it cancels any ordinary update still waiting.
- R4: An ordinary update (`flagUpdEn`=1, `flagUpdRet`=0) is not used by the first boundary at or after it, which still decides with the previous flag. The new value is committed at that boundary and used from the next boundary on. When several ordinary updates arrive before that boundary, the latest one wins.
- R5: A `hwReq` pulse sets that source's request bit. Accepting a source clears its request bit.
- R6: A control write (`ctlWrEn`) to source `ctlWrSel` loads its level from `ctlWrLvl`. With `ctlWrReq`=0 it clears the request bit. With `ctlWrReq`=1 the request bit is left unchanged.
- R7: A source qualifies only if its level is strictly greater than the IPL. A source with level 0 is never accepted.
- R8: Among qualifying sources, the highest level wins. When levels are equal, the lowest source index wins.
- R9: On acceptance the IPL takes the winning level and the enable flag becomes 0. In that same cycle, acceptance overrides a return update's value and cancels a pending or arriving ordinary update.
- R10: Acceptance at a boundary in cycle t gives `acceptStb`=1 in cycle t+1 only, with `acceptIdx` and `acceptLvl` giving the winner's index and level.
- R11: When a `hwReq` pulse and a clear (by software or by acceptance) hit the same request bit in one cycle, the bit ends up set.
- R12: `iplWrEn` loads the IPL from `iplWrData`. An acceptance in the same cycle takes precedence over this write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwReq | input | NUM_SRC | Per-source hardware request pulses |
| ctlWrEn | input | 1 | Source control write strobe |
| ctlWrSel | input | IDX_W | Source addressed by the control write |
| ctlWrLvl | input | LVL_W | Priority level written |
| ctlWrReq | input | 1 | Request-bit value written (only 0 acts) |
| iplWrEn | input | 1 | IPL write strobe |
| iplWrData | input | LVL_W | IPL value written |
| boundary | input | 1 | Instruction-boundary strobe |
| flagUpdEn | input | 1 | Enable-flag update command |
| flagUpdRet | input | 1 | 1: return-from-interrupt update, 0: ordinary update |
| flagUpdVal | input | 1 | New enable-flag value |
| acceptStb | output | 1 | One-cycle acceptance pulse |
| acceptIdx | output | IDX_W | Accepted source index |
| acceptLvl | output | LVL_W | Accepted source level |

## Verification
Several functions can fall on the same cycle, and the bench drives each such pair together in one cycle. The main case is a hardware pulse arriving together with a software clear of the same request bit. The bench judges it by a later acceptance of that source. Two other collisions are also provoked: an acceptance against an ordinary enable update waiting to commit, and an acceptance against a software IPL write. In each of these, the bench judges the outcome by whether a following boundary accepts a lower-level request.

// File: rtl/int_accept_pkg.sv
`timescale 1ns/1ps
package int_accept_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic takeIrq;   // accept the current winner this cycle
    logic iplSwLd;   // software IPL write survives (no acceptance)
  } accStrobe_t;

endpackage

// File: rtl/int_accept_ctrl.sv
`timescale 1ns/1ps
module int_accept_ctrl
  import int_accept_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       boundary,
  input  logic       flagUpdEn,
  input  logic       flagUpdRet,
  input  logic       flagUpdVal,
  input  logic       iplWrEn,
  input  logic       anyQual,
  output accStrobe_t strobes
);

  logic flagQ;
  logic pendValidQ;
  logic pendValQ;

  logic retUpd;
  logic ordUpd;
  logic effFlag;
  logic pendHave;
  logic pendVal;
  logic takeIrq;

  assign retUpd   = flagUpdEn &  flagUpdRet;
  assign ordUpd   = flagUpdEn & ~flagUpdRet;
  // Return updates bypass straight into this boundary's decision.
  assign effFlag  = retUpd ? flagUpdVal : flagQ;
  assign pendHave = ordUpd | pendValidQ;
  assign pendVal  = ordUpd ? flagUpdVal : pendValQ;
  assign takeIrq  = boundary & effFlag & anyQual;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ      <= 1'b0;
      pendValidQ <= 1'b0;
      pendValQ   <= 1'b0;
    end else if (takeIrq) begin
      flagQ      <= 1'b0;
      pendValidQ <= 1'b0;
    end else if (retUpd) begin
      flagQ      <= flagUpdVal;
      pendValidQ <= 1'b0;
    end else if (boundary && pendHave) begin
      // Ordinary update commits after this boundary has decided.
      flagQ      <= pendVal;
      pendValidQ <= 1'b0;
    end else if (ordUpd) begin
      pendValidQ <= 1'b1;
      pendValQ   <= flagUpdVal;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.takeIrq = takeIrq;
    strobes.iplSwLd = iplWrEn & ~takeIrq;
  end

  AST_FLAG_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !retUpd && !flagQ) |-> !strobes.takeIrq); // R1

  AST_RET_NOW: assert property (@(posedge clk) disable iff (!rstN)
    (retUpd && !takeIrq) |=> (flagQ == $past(flagUpdVal))); // R3

  AST_ORD_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    (ordUpd && !boundary) |=> (flagQ == $past(flagQ))); // R4

  AST_FLAG_CLR_ON_ACC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeIrq |=> !flagQ); // R9

endmodule

// File: rtl/int_accept_dp.sv
`timescale 1ns/1ps
module int_accept_dp
  import int_accept_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               ctlWrEn,
  input  logic [IDX_W-1:0]   ctlWrSel,
  input  logic [LVL_W-1:0]   ctlWrLvl,
  input  logic               ctlWrReq,
  input  logic [LVL_W-1:0]   iplWrData,
  input  accStrobe_t         strobes,
  output logic               anyQual,
  output logic               acceptStb,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic [LVL_W-1:0]   acceptLvl
);

  logic [NUM_SRC-1:0] reqQ;
  logic [LVL_W-1:0]   lvlQ [NUM_SRC];
  logic [NUM_SRC-1:0] qual;
  logic [LVL_W-1:0]   iplQ;
  logic [IDX_W-1:0]   winIdx;
  logic [LVL_W-1:0]   winLvl;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic hit;
    logic clrReq;
    assign hit    = ctlWrEn && (ctlWrSel == IDX_W'(g));
    assign clrReq = (hit && !ctlWrReq) ||
                    (strobes.takeIrq && (winIdx == IDX_W'(g)));
    assign qual[g] = reqQ[g] && (lvlQ[g] > iplQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqQ[g] <= 1'b0;
        lvlQ[g] <= '0;
      end else begin
        if (hwReq[g])    reqQ[g] <= 1'b1;   // set beats any clear
        else if (clrReq) reqQ[g] <= 1'b0;
        if (hit)         lvlQ[g] <= ctlWrLvl;
      end
    end
  end

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    winIdx = '0;
    winLvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qual[i] && (lvlQ[i] >= winLvl)) begin
        winIdx = IDX_W'(i);
        winLvl = lvlQ[i];
      end
    end
  end

  assign anyQual = |qual;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iplQ      <= '0;
      acceptStb <= 1'b0;
      acceptIdx <= '0;
      acceptLvl <= '0;
    end else begin
      acceptStb <= strobes.takeIrq;
      if (strobes.takeIrq) begin
        iplQ      <= winLvl;
        acceptIdx <= winIdx;
        acceptLvl <= winLvl;
      end else if (strobes.iplSwLd) begin
        iplQ      <= iplWrData;
      end
    end
  end

  AST_WIN_QUALIFIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeIrq |-> (reqQ[winIdx] && (lvlQ[winIdx] > iplQ))); // R7

  AST_NONZERO_LVL: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> (acceptLvl != '0)); // R7

  AST_IPL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeIrq |=> (iplQ == $past(winLvl))); // R9

  AST_REQ_CLR_ON_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeIrq && !hwReq[winIdx]) |=> !reqQ[$past(winIdx)]); // R5

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|hwReq) |=> ((reqQ & $past(hwReq)) == $past(hwReq))); // R11

endmodule

// File: rtl/int_accept_top.sv
`timescale 1ns/1ps
module int_accept_top
  import int_accept_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               ctlWrEn,
  input  logic [IDX_W-1:0]   ctlWrSel,
  input  logic [LVL_W-1:0]   ctlWrLvl,
  input  logic               ctlWrReq,
  input  logic               iplWrEn,
  input  logic [LVL_W-1:0]   iplWrData,
  input  logic               boundary,
  input  logic               flagUpdEn,
  input  logic               flagUpdRet,
  input  logic               flagUpdVal,
  output logic               acceptStb,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic [LVL_W-1:0]   acceptLvl
);

  accStrobe_t strobes;
  logic       anyQual;

  int_accept_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .boundary   (boundary),
    .flagUpdEn  (flagUpdEn),
    .flagUpdRet (flagUpdRet),
    .flagUpdVal (flagUpdVal),
    .iplWrEn    (iplWrEn),
    .anyQual    (anyQual),
    .strobes    (strobes)
  );

  int_accept_dp #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hwReq     (hwReq),
    .ctlWrEn   (ctlWrEn),
    .ctlWrSel  (ctlWrSel),
    .ctlWrLvl  (ctlWrLvl),
    .ctlWrReq  (ctlWrReq),
    .iplWrData (iplWrData),
    .strobes   (strobes),
    .anyQual   (anyQual),
    .acceptStb (acceptStb),
    .acceptIdx (acceptIdx),
    .acceptLvl (acceptLvl)
  );

endmodule

// File: tb/int_accept_top_bench.sv
`timescale 1ns/1ps
module int_accept_top_bench;

  localparam int NS = 8;
  localparam int LW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] hwReq = '0;
  logic          ctlWrEn = 1'b0;
  logic [IW-1:0] ctlWrSel = '0;
  logic [LW-1:0] ctlWrLvl = '0;
  logic          ctlWrReq = 1'b0;
  logic          iplWrEn = 1'b0;
  logic [LW-1:0] iplWrData = '0;
  logic          boundary = 1'b0;
  logic          flagUpdEn = 1'b0;
  logic          flagUpdRet = 1'b0;
  logic          flagUpdVal = 1'b0;
  logic          acceptStb;
  logic [IW-1:0] acceptIdx;
  logic [LW-1:0] acceptLvl;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  int_accept_top #(.NUM_SRC(NS), .LVL_W(LW)) u_int_accept_top (
    .clk(clk), .rstN(rstN), .hwReq(hwReq),
    .ctlWrEn(ctlWrEn), .ctlWrSel(ctlWrSel), .ctlWrLvl(ctlWrLvl), .ctlWrReq(ctlWrReq),
    .iplWrEn(iplWrEn), .iplWrData(iplWrData), .boundary(boundary),
    .flagUpdEn(flagUpdEn), .flagUpdRet(flagUpdRet), .flagUpdVal(flagUpdVal),
    .acceptStb(acceptStb), .acceptIdx(acceptIdx), .acceptLvl(acceptLvl)
  );

  always #5 clk = ~clk;

  // Levels programmed per source: 3,5,5,0,7,2,7,1 for indices 0..7.
  localparam logic [LW-1:0] LVL_TAB [NS] = '{3'd3, 3'd5, 3'd5, 3'd0, 3'd7, 3'd2, 3'd7, 3'd1};

  // {request mask, IPL, expected strobe, expected index, expected level}
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {8'h06, 3'd0, 1'b1, 3'd1, 3'd5},
    {8'h50, 3'd0, 1'b1, 3'd4, 3'd7},
    {8'h08, 3'd0, 1'b0, 3'd0, 3'd0},
    {8'h21, 3'd2, 1'b1, 3'd0, 3'd3},
    {8'h21, 3'd3, 1'b0, 3'd0, 3'd0},
    {8'h80, 3'd0, 1'b1, 3'd7, 3'd1},
    {8'hFF, 3'd6, 1'b1, 3'd4, 3'd7},
    {8'hFF, 3'd7, 1'b0, 3'd0, 3'd0},
    {8'h24, 3'd4, 1'b1, 3'd2, 3'd5}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    hwReq = '0; ctlWrEn = 0; ctlWrReq = 0; iplWrEn = 0;
    boundary = 0; flagUpdEn = 0; flagUpdRet = 0; flagUpdVal = 0;
  endtask

  task automatic ctlWr(input int idx, input logic reqVal);
    ctlWrEn = 1; ctlWrSel = IW'(idx); ctlWrLvl = LVL_TAB[idx]; ctlWrReq = reqVal;
    cyc(); clearIn();
  endtask

  task automatic wrIpl(input int v);
    iplWrEn = 1; iplWrData = LW'(v);
    cyc(); clearIn();
  endtask

  task automatic pulseHw(input logic [NS-1:0] m);
    hwReq = m;
    cyc(); clearIn();
  endtask

  task automatic flagCmd(input logic ret, input logic val, input logic bnd);
    flagUpdEn = 1; flagUpdRet = ret; flagUpdVal = val; boundary = bnd;
    cyc(); clearIn();
  endtask

  task automatic bnd();
    boundary = 1;
    cyc(); clearIn();
  endtask

  task automatic expAcc(input string req, input int idx, input int lvl);
    chk(req, acceptStb, 1);
    chk(req, acceptIdx, idx);
    chk(req, acceptLvl, lvl);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) cyc();
    chk("R2 stb at reset", acceptStb, 0);
    chk("R2 idx at reset", acceptIdx, 0);
    rstN = 1;
    cyc();

    for (int i = 0; i < NS; i++) ctlWr(i, 1'b0);

    // R2/R1: flag resets to 0, so a pending qualifying request is not taken.
    pulseHw(8'h10);
    bnd();
    chk("R2 R1 flag reset blocks", acceptStb, 0);

    // R4: ordinary set with boundary, decision still uses old flag.
    flagCmd(1'b0, 1'b1, 1'b1);
    chk("R4 ordinary set same boundary", acceptStb, 0);
    bnd();
    expAcc("R4 ordinary set next boundary", 4, 7);

    // R4: ordinary set without boundary waits one whole boundary.
    wrIpl(0);
    pulseHw(8'h02);
    flagCmd(1'b0, 1'b1, 1'b0);
    chk("R4 ordinary no boundary", acceptStb, 0);
    bnd();
    chk("R4 first boundary old flag", acceptStb, 0);
    bnd();
    expAcc("R4 second boundary", 1, 5);
    cyc();
    chk("R10 strobe one cycle", acceptStb, 0);

    // R9: IPL loaded with 5 and flag cleared.
    pulseHw(8'h04);
    flagCmd(1'b1, 1'b1, 1'b1);
    chk("R9 R7 IPL equals level", acceptStb, 0);
    bnd();
    chk("R3 R7 flag held still blocked", acceptStb, 0);
    wrIpl(4);
    bnd();
    expAcc("R3 R12 held flag, lower IPL", 2, 5);

    // R4: ordinary clear does not block the boundary it arrives with.
    wrIpl(7);
    pulseHw(8'h10);
    flagCmd(1'b1, 1'b1, 1'b1);
    chk("R7 level 7 vs IPL 7", acceptStb, 0);
    wrIpl(0);
    flagCmd(1'b0, 1'b0, 1'b1);
    expAcc("R4 ordinary clear deferred", 4, 7);
    wrIpl(0);
    pulseHw(8'h10);
    bnd();
    chk("R1 flag 0 after accept", acceptStb, 0);

    // R3: return clear applies at once.
    flagCmd(1'b1, 1'b1, 1'b0);
    chk("R3 return set no boundary", acceptStb, 0);
    flagCmd(1'b1, 1'b0, 1'b1);
    chk("R3 return clear immediate", acceptStb, 0);
    bnd();
    chk("R3 R1 return clear held", acceptStb, 0);

    // R6: software clear removes the request.
    ctlWr(4, 1'b0);
    flagCmd(1'b1, 1'b1, 1'b1);
    chk("R6 software clear", acceptStb, 0);

    // R6: software write of 1 does nothing.
    ctlWr(0, 1'b1);
    bnd();
    chk("R6 write 1 ignored", acceptStb, 0);

    // R11: hardware set and software clear in one cycle.
    hwReq = 8'h01; ctlWrEn = 1; ctlWrSel = 3'd0; ctlWrLvl = LVL_TAB[0]; ctlWrReq = 0;
    cyc(); clearIn();
    bnd();
    expAcc("R11 hw set beats sw clear", 0, 3);

    // R5: accepted request is cleared.
    wrIpl(0);
    flagCmd(1'b1, 1'b1, 1'b1);
    chk("R5 accepted request cleared", acceptStb, 0);

    // R12: acceptance beats a software IPL write in the same cycle.
    pulseHw(8'h40);
    boundary = 1; iplWrEn = 1; iplWrData = 3'd2;
    cyc(); clearIn();
    expAcc("R12 accept with IPL write", 6, 7);
    pulseHw(8'h02);
    flagCmd(1'b1, 1'b1, 1'b1);
    chk("R12 IPL kept accepted level", acceptStb, 0);

    // R9: acceptance cancels an arriving ordinary update.
    wrIpl(0);
    flagCmd(1'b0, 1'b1, 1'b1);
    expAcc("R9 R5 accept with ordinary set", 1, 5);
    wrIpl(0);
    pulseHw(8'h20);
    bnd();
    chk("R9 ordinary update cancelled", acceptStb, 0);
    bnd();
    chk("R9 still cancelled", acceptStb, 0);

    // R8/R7 table walk.
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < NS; i++) ctlWr(i, 1'b0);
      wrIpl(int'(VEC[v][9:7]));
      pulseHw(VEC[v][17:10]);
      flagCmd(1'b1, 1'b1, 1'b1);
      chk($sformatf("R8 R7 vec%0d stb", v), acceptStb, int'(VEC[v][6]));
      if (VEC[v][6]) begin
        chk($sformatf("R8 vec%0d idx", v), acceptIdx, int'(VEC[v][5:3]));
        chk($sformatf("R10 vec%0d lvl", v), acceptLvl, int'(VEC[v][2:0]));
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule